// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block is a single-way data cache that sits between a processor load/store port and a word-wide bus master. Each request carries a kind (plain load, refresh load, direct load, plain store, direct store) and a cacheable flag. The block splits the address into tag, line index and byte offset and looks the index up in a tag array that holds one tag and one valid bit per line. It then chooses the bus and cache action from the kind, the hit result and the cacheable flag. A plain load that hits is answered from the data array. A cacheable miss refills the whole line from the bus. Stores are always passed on to a write-buffer port, so no line is ever dirty.

All data-carrying interfaces use valid/ready. Back-pressure rules:
- The request port accepts one request per transfer and takes no new request until the current one has finished.
- Load responses, bus read addresses and write-buffer entries hold their valid and payload steady until the receiver raises ready.
- Bus read data has no ready. The block has at most one read outstanding and always takes the returned word.

A flush input invalidates every line, one index per cycle, while the request port is held not ready.

Top module: `wt_dcache`

## Requirements
- R1: The address is split with bits 4:0 as byte offset, bits 11:5 as line index (128 lines) and bits 31:12 as tag. A hit needs a valid line at the index whose stored tag equals all 20 tag bits.
- R2: A plain load (kind 0) that hits returns the addressed 32-bit word with no bus read. Response valid rises on the second clock edge after acceptance.
- R3: A plain load that misses with the cacheable flag set reads all eight words of the line at word addresses 0..7 in increasing order. It then marks the line valid with the new tag, and the response carries the addressed word.
- R4: A load that misses with the cacheable flag clear makes exactly one bus read of the addressed word and does not allocate a line.
- R5: A refresh load (kind 1) always reads the bus. On a hit it makes one read and writes the returned word into the cached line. On a miss it behaves as a plain load miss.
- R6: A direct load (kind 2) makes one bus read, returns that word and leaves the cache contents unchanged. Kind codes 5 to 7 are treated the same way.
- R7: A plain store (kind 3) issues one write-buffer entry with the word-aligned address, the data and the byte enables, whatever the cacheable flag. On a hit it also updates the enabled bytes of the cached word. On a miss it allocates nothing.
- R8: A direct store (kind 4) issues one write-buffer entry and never changes the cached data.
- R9: A flush pulse clears every valid bit. While the flush runs, request ready stays low for 128 cycles, one per index.
- R10: The response, bus read address and write-buffer outputs keep valid high and their payload steady until accepted.
- R11: After reset, request ready is high and response valid, bus read valid and write-buffer valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 3 | 0 load, 1 refresh load, 2 direct load, 3 store, 4 direct store |
| req_cacheable | input | 1 | Load may allocate on miss |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, already lane-aligned |
| req_be | input | 4 | Store byte enables |
| rsp_valid | output | 1 | Load data available |
| rsp_ready | input | 1 | Load data taken |
| rsp_data | output | 32 | Loaded word |
| rd_req_valid | output | 1 | Bus read request |
| rd_req_ready | input | 1 | Bus read request taken |
| rd_addr | output | 32 | Word-aligned bus read address |
| rd_data_valid | input | 1 | Bus read data present |
| rd_data | input | 32 | Bus read data |
| wb_valid | output | 1 | Write-buffer entry present |
| wb_ready | input | 1 | Write buffer took the entry |
| wb_addr | output | 32 | Word-aligned store address |
| wb_data | output | 32 | Store data |
| wb_be | output | 4 | Store byte enables |

## Verification
After acceptance, a request spends one edge in lookup. A hit load therefore shows response valid, and a store shows write-buffer valid, at the second edge, and the bench measures that delay exactly. Results that involve bus reads are due one edge after the last read word arrives. The bench does not predict those cycles; it waits for the response handshake and then compares the data, the number of reads and the order of the read addresses against a reference model. All inputs are driven and all outputs sampled on the falling edge, so each handshake seen there completes on the following rising edge.

// File: rtl/wtdc_pkg.sv
package wtdc_pkg;

  typedef enum logic [2:0] {
    K_LOAD         = 3'd0,
    K_LOAD_REFRESH = 3'd1,
    K_LOAD_DIRECT  = 3'd2,
    K_STORE        = 3'd3,
    K_STORE_DIRECT = 3'd4
  } req_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DECIDE,
    S_RD_ADDR,
    S_RD_DATA,
    S_RESP,
    S_WBUF,
    S_FLUSH
  } ctl_state_e;

endpackage

// File: rtl/wtdc_tag_store.sv
module wtdc_tag_store #(
  parameter int LINES = 128,
  parameter int IDX_W = 7,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [TAG_W-1:0] lk_tag,
  output logic             lk_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx
);

  logic [LINES-1:0] vld;
  logic [TAG_W-1:0] tags [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (inv_en) vld[inv_idx] <= 1'b0;
      if (wr_en)  vld[wr_idx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_idx] <= wr_tag;
  end

  assign lk_tag   = tags[lk_idx];
  assign lk_valid = vld[lk_idx];

  // R9: invalidation (flush or fill start) never coincides with allocation
  a_r9_inv_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_en && wr_en));

endmodule

// File: rtl/wtdc_data_store.sv
module wtdc_data_store #(
  parameter int WORDS  = 1024,
  parameter int AW     = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic [AW-1:0]       rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0]   wr_data
);

  localparam int BE_W = DATA_W / 8;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be[b]) mem[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import wtdc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int CACHE_BYTES = 4096
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2:0]          req_kind,
  input  logic                req_cacheable,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                rd_req_valid,
  input  logic                rd_req_ready,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rd_data_valid,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                wb_valid,
  input  logic                wb_ready,
  output logic [ADDR_W-1:0]   wb_addr,
  output logic [DATA_W-1:0]   wb_data,
  output logic [DATA_W/8-1:0] wb_be
);

  localparam int BE_W   = DATA_W / 8;
  localparam int BOFF_W = $clog2(BE_W);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WPL    = LINE_BYTES / BE_W;
  localparam int WOFF_W = OFF_W - BOFF_W;
  localparam int LINES  = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int DAW    = IDX_W + WOFF_W;

  ctl_state_e          st;
  req_kind_e           q_kind;
  logic                q_cach, q_fill, q_upd, flush_pend;
  logic [ADDR_W-1:0]   q_addr;
  logic [DATA_W-1:0]   q_wdata, rsp_q;
  logic [BE_W-1:0]     q_be;
  logic [WOFF_W-1:0]   wcnt;
  logic [IDX_W-1:0]    fcnt;

  logic [IDX_W-1:0]    q_idx;
  logic [TAG_W-1:0]    q_tag;
  logic [WOFF_W-1:0]   q_word;
  assign q_idx  = q_addr[OFF_W +: IDX_W];
  assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];
  assign q_word = q_addr[BOFF_W +: WOFF_W];

  // tag lookup and data array
  logic [TAG_W-1:0]  lk_tag;
  logic              lk_valid, hit;
  logic              ts_we, inv_en;
  logic [IDX_W-1:0]  inv_idx;
  logic              ds_we;
  logic [DAW-1:0]    ds_wa;
  logic [BE_W-1:0]   ds_be;
  logic [DATA_W-1:0] ds_wd, ds_rd;
  logic              start_fill, is_load_k;

  wtdc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(q_idx), .lk_tag(lk_tag), .lk_valid(lk_valid),
    .wr_en(ts_we), .wr_idx(q_idx), .wr_tag(q_tag),
    .inv_en(inv_en), .inv_idx(inv_idx)
  );

  wtdc_data_store #(.WORDS(LINES*WPL), .AW(DAW), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .rd_addr({q_idx, q_word}), .rd_data(ds_rd),
    .wr_en(ds_we), .wr_addr(ds_wa), .wr_be(ds_be), .wr_data(ds_wd)
  );

  assign hit        = lk_valid && (lk_tag == q_tag);
  assign is_load_k  = (q_kind == K_LOAD) || (q_kind == K_LOAD_REFRESH);
  assign start_fill = (st == S_DECIDE) && is_load_k && !hit && q_cach;

  // array write and invalidate controls
  always_comb begin
    ds_we   = 1'b0;
    ds_wa   = {q_idx, q_word};
    ds_be   = q_be;
    ds_wd   = q_wdata;
    ts_we   = 1'b0;
    inv_en  = 1'b0;
    inv_idx = q_idx;
    unique case (st)
      S_DECIDE: begin
        if (q_kind == K_STORE && hit) ds_we = 1'b1;
        if (start_fill) inv_en = 1'b1;
      end
      S_RD_DATA: begin
        if (rd_data_valid && q_fill) begin
          ds_we = 1'b1;
          ds_wa = {q_idx, wcnt};
          ds_be = '1;
          ds_wd = rd_data;
          if (wcnt == WOFF_W'(WPL-1)) ts_we = 1'b1;
        end else if (rd_data_valid && q_upd) begin
          ds_we = 1'b1;
          ds_be = '1;
          ds_wd = rd_data;
        end
      end
      S_FLUSH: begin
        inv_en  = 1'b1;
        inv_idx = fcnt;
      end
      default: ;
    endcase
  end

  // control sequence
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      flush_pend <= 1'b0;
      q_kind     <= K_LOAD;
      q_cach     <= 1'b0;
      q_fill     <= 1'b0;
      q_upd      <= 1'b0;
      q_addr     <= '0;
      q_wdata    <= '0;
      q_be       <= '0;
      rsp_q      <= '0;
      wcnt       <= '0;
      fcnt       <= '0;
    end else begin
      if (flush && st != S_IDLE) flush_pend <= 1'b1;
      unique case (st)
        S_IDLE: begin
          if (flush || flush_pend) begin
            st         <= S_FLUSH;
            fcnt       <= '0;
            flush_pend <= 1'b0;
          end else if (req_valid) begin
            q_kind  <= req_kind_e'(req_kind);
            q_cach  <= req_cacheable;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
            q_be    <= req_be;
            st      <= S_DECIDE;
          end
        end
        S_DECIDE: begin
          q_fill <= 1'b0;
          q_upd  <= 1'b0;
          wcnt   <= '0;
          if (q_kind == K_STORE || q_kind == K_STORE_DIRECT) begin
            st <= S_WBUF;
          end else if (q_kind == K_LOAD && hit) begin
            rsp_q <= ds_rd;
            st    <= S_RESP;
          end else if (q_kind == K_LOAD_REFRESH && hit) begin
            q_upd <= 1'b1;
            st    <= S_RD_ADDR;
          end else begin
            q_fill <= start_fill;
            st     <= S_RD_ADDR;
          end
        end
        S_RD_ADDR: if (rd_req_ready) st <= S_RD_DATA;
        S_RD_DATA: begin
          if (rd_data_valid) begin
            if (q_fill) begin
              if (wcnt == q_word) rsp_q <= rd_data;
              if (wcnt == WOFF_W'(WPL-1)) begin
                st <= S_RESP;
              end else begin
                wcnt <= wcnt + 1'b1;
                st   <= S_RD_ADDR;
              end
            end else begin
              rsp_q <= rd_data;
              st    <= S_RESP;
            end
          end
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        S_WBUF: if (wb_ready)  st <= S_IDLE;
        S_FLUSH: begin
          fcnt <= fcnt + 1'b1;
          if (fcnt == IDX_W'(LINES-1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == S_IDLE) && !flush && !flush_pend;
  assign rsp_valid    = (st == S_RESP);
  assign rsp_data     = rsp_q;
  assign rd_req_valid = (st == S_RD_ADDR);
  assign rd_addr      = q_fill ? {q_addr[ADDR_W-1:OFF_W], wcnt, {BOFF_W{1'b0}}}
                               : {q_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
  assign wb_valid     = (st == S_WBUF);
  assign wb_addr      = {q_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
  assign wb_data      = q_wdata;
  assign wb_be        = q_be;

  // R10: stalled outputs stay put
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));
  a_r10_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data) && $stable(wb_be));
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R2: the lookup cycle after acceptance issues nothing on the bus
  a_r2_lookup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !rd_req_valid && !wb_valid && !rsp_valid);
  // R7: one write-buffer entry per store
  a_r7_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready |=> !wb_valid);

endmodule

// File: tb/sim_wt_dcache.sv
module sim_wt_dcache;

  logic        clk = 1'b0;
  logic        rst_n, flush;
  logic        req_valid, req_ready, req_cacheable;
  logic [2:0]  req_kind;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_data;
  logic        rd_req_valid, rd_req_ready, rd_data_valid;
  logic [31:0] rd_addr, rd_data;
  logic        wb_valid, wb_ready;
  logic [31:0] wb_addr, wb_data;
  logic [3:0]  wb_be;

  always #4 clk = ~clk;

  wt_dcache u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] bmem [4096];
  logic        mv [128];
  logic [19:0] mt [128];
  logic [31:0] md [1024];

  int rd_cnt = 0, wb_cnt = 0, rsp_cnt = 0;
  logic [31:0] rd_log [256];
  logic [31:0] wb_last_a, wb_last_d, rsp_last;
  logic [3:0]  wb_last_be;
  logic        rd_pend = 0, rd_stall = 0, rsp_stall = 0;
  logic [31:0] rd_pend_a, stall_a, stall_d;
  int          rd_lat = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // bus, write buffer and response partners
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_stall) chk(rd_req_valid && rd_addr == stall_a, "R10 read hold", rd_addr, stall_a);
      if (rsp_stall) chk(rsp_valid && rsp_data == stall_d, "R10 rsp hold", rsp_data, stall_d);
      rd_data_valid = 1'b0;
      if (rd_pend) begin
        if (rd_lat == 0) begin
          rd_data_valid = 1'b1;
          rd_data = bmem[rd_pend_a[13:2]];
          rd_pend = 1'b0;
        end else rd_lat--;
      end
      rd_req_ready = ($urandom % 4) != 0;
      rd_stall = rd_req_valid && !rd_req_ready;
      stall_a = rd_addr;
      if (rd_req_valid && rd_req_ready) begin
        rd_log[rd_cnt % 256] = rd_addr;
        rd_cnt++;
        rd_pend = 1'b1;
        rd_pend_a = rd_addr;
        rd_lat = $urandom % 3;
      end
      wb_ready = ($urandom % 3) != 0;
      if (wb_valid && wb_ready) begin
        for (int b = 0; b < 4; b++)
          if (wb_be[b]) bmem[wb_addr[13:2]][b*8 +: 8] = wb_data[b*8 +: 8];
        wb_last_a = wb_addr; wb_last_d = wb_data; wb_last_be = wb_be;
        wb_cnt++;
      end
      rsp_ready = ($urandom % 3) != 0;
      rsp_stall = rsp_valid && !rsp_ready;
      stall_d = rsp_data;
      if (rsp_valid && rsp_ready) begin
        rsp_last = rsp_data;
        rsp_cnt++;
      end
    end
  end

  int last_reads;

  task automatic do_op(input logic [2:0] k, input bit c, input logic [31:0] a,
                       input logic [31:0] wd, input logic [3:0] be);
    logic [6:0]  idx = a[11:5];
    logic [19:0] tg  = a[31:12];
    logic [9:0]  li  = {a[11:5], a[4:2]};
    bit hit  = mv[idx] && mt[idx] == tg;
    bit load = (k <= 3'd2);
    bit fill = 0, upd = 0;
    int exp_rd = 0, lat = 0, rd0 = rd_cnt, wb0 = wb_cnt, rs0 = rsp_cnt;
    logic [31:0] exp_d = bmem[a[13:2]];
    string rq;
    case (k)
      3'd0: begin
        if (hit) begin exp_d = md[li]; rq = "R2"; end
        else if (c) begin fill = 1; exp_rd = 8; rq = "R3"; end
        else begin exp_rd = 1; rq = "R4"; end
      end
      3'd1: begin
        rq = "R5";
        if (hit) begin exp_rd = 1; upd = 1; end
        else if (c) begin fill = 1; exp_rd = 8; end
        else exp_rd = 1;
      end
      3'd2: begin exp_rd = 1; rq = "R6"; end
      3'd3: rq = "R7";
      default: rq = "R8";
    endcase
    @(negedge clk);
    req_valid = 1; req_kind = k; req_cacheable = c; req_addr = a; req_wdata = wd; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!(load ? rsp_valid : wb_valid)) begin @(negedge clk); lat++; end
    if (load) begin
      while (rsp_cnt == rs0) @(negedge clk);
      chk(rsp_last == exp_d, {rq, " load data"}, rsp_last, exp_d);
      chk(rd_cnt - rd0 == exp_rd, {rq, " read count"}, rd_cnt - rd0, exp_rd);
      if (k == 3'd0 && hit) chk(lat == 1, "R2 hit latency", lat, 1);
      if (fill) begin
        bit ok = 1;
        for (int j = 0; j < 8; j++)
          if (rd_log[(rd0 + j) % 256] != {a[31:5], j[2:0], 2'b00}) ok = 0;
        chk(ok, "R3 fill order", rd_log[rd0 % 256], {a[31:5], 5'd0});
        for (int j = 0; j < 8; j++) md[{idx, j[2:0]}] = bmem[{a[13:5], j[2:0]}];
        mv[idx] = 1; mt[idx] = tg;
      end
      if (upd) md[li] = exp_d;
    end else begin
      while (wb_cnt == wb0) @(negedge clk);
      chk(lat == 1, {rq, " store latency"}, lat, 1);
      chk(wb_last_a == {a[31:2], 2'b00}, {rq, " wb addr"}, wb_last_a, {a[31:2], 2'b00});
      chk(wb_last_d == wd && wb_last_be == be, {rq, " wb data"}, wb_last_d, wd);
      chk(rd_cnt == rd0, {rq, " no read"}, rd_cnt - rd0, 0);
      if (k == 3'd3 && hit)
        for (int b = 0; b < 4; b++) if (be[b]) md[li][b*8 +: 8] = wd[b*8 +: 8];
    end
    last_reads = rd_cnt - rd0;
  endtask

  task automatic do_flush();
    int low = 0;
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    while (!req_ready) begin low++; @(negedge clk); end
    chk(low == 128, "R9 flush ready low", low, 128);
    for (int i = 0; i < 128; i++) mv[i] = 0;
  endtask

  localparam logic [31:0] A = 32'h0000_0040;

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) bmem[i] = i * 32'h9E37_79B1 ^ 32'h5A5A_0000;
    for (int i = 0; i < 128; i++) mv[i] = 0;
    rst_n = 0; flush = 0; req_valid = 0; req_kind = 0; req_cacheable = 0;
    req_addr = 0; req_wdata = 0; req_be = 0;
    rsp_ready = 0; rd_req_ready = 0; rd_data_valid = 0; rd_data = 0; wb_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1, "R11 ready", req_ready, 1);
    chk(!rsp_valid && !rd_req_valid && !wb_valid, "R11 valids low",
        {rsp_valid, rd_req_valid, wb_valid}, 0);
    do_op(0, 1, A, 0, 0);                 // R3 fill
    do_op(0, 1, A + 32'h1C, 0, 0);        // R2 hit
    // R1: tag bits 12 and 31 each take part in the compare
    do_op(0, 1, A | 32'h1000, 0, 0);
    chk(last_reads == 8, "R1 tag bit12 miss", last_reads, 8);
    do_op(0, 1, A | 32'h8000_0000, 0, 0);
    chk(last_reads == 8, "R1 tag bit31 miss", last_reads, 8);
    do_op(0, 1, A + 32'h4, 0, 0);
    chk(last_reads == 8, "R1 refill after alias", last_reads, 8);
    do_op(0, 1, A + 32'h8, 0, 0);
    chk(last_reads == 0, "R1 same line hit", last_reads, 0);
    // R4 uncached miss twice
    do_op(0, 0, 32'h0000_0100, 0, 0);
    do_op(0, 0, 32'h0000_0100, 0, 0);
    chk(last_reads == 1, "R4 no allocate", last_reads, 1);
    // R6 / R5 with memory changed behind the cache
    bmem[A[13:2]] = 32'hCAFE_0001;
    do_op(0, 1, A, 0, 0);
    do_op(2, 1, A, 0, 0);
    do_op(0, 1, A, 0, 0);
    chk(rsp_last != 32'hCAFE_0001, "R6 cache untouched", rsp_last, 0);
    do_op(1, 1, A, 0, 0);
    do_op(0, 1, A, 0, 0);
    chk(rsp_last == 32'hCAFE_0001, "R5 refreshed", rsp_last, 32'hCAFE_0001);
    // R7 store hit merge, store miss no allocate
    do_op(3, 1, A, 32'h1122_3344, 4'b0101);
    do_op(0, 1, A, 0, 0);
    do_op(3, 1, 32'h0000_0300, 32'hDEAD_BEEF, 4'hF);
    do_op(0, 1, 32'h0000_0300, 0, 0);
    chk(last_reads == 8, "R7 store miss no allocate", last_reads, 8);
    // R8 direct store leaves cache
    do_op(4, 1, A, 32'h5555_AAAA, 4'hF);
    do_op(0, 1, A, 0, 0);
    chk(rsp_last != 32'h5555_AAAA, "R8 cache unchanged", rsp_last, 0);
    // R9 flush
    do_flush();
    do_op(0, 1, A, 0, 0);
    chk(last_reads == 8, "R9 miss after flush", last_reads, 8);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a = {18'd0, 2'($urandom % 4), 7'($urandom % 6), 3'($urandom % 8), 2'b00};
      logic [3:0]  be = 4'($urandom % 15 + 1);
      do_op(3'($urandom % 5), ($urandom % 4) != 0, a, $urandom, be);
      if (n == 200) do_flush();
    end
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule